// File: doc/BRIEF.md
# Eye Mask Violation Classifier

This block grades the quality of a received serial bit stream against a rectangular keep-out mask. The mask is bounded in time by an early and a late sampling instant inside each bit period, and in amplitude by an upper and a lower threshold. For each instant the block receives two comparator decisions that were latched earlier: one against the upper threshold and one against the lower threshold. A point violates the mask when the sampled level lies between the two thresholds.

For every qualified bit period the block emits one pulse. UP means no violation. DOWN means a light violation at exactly one instant. BAD means a severe violation at both instants. An equalizer or adaptation loop uses these pulses to steer its settings. Two saturating counters total the violations at the early and late instants separately, so that horizontal asymmetry of the eye can be read out. A per-point enable drops either check so that narrower mask shapes can be applied. A centre-of-eye sample passes through as the recovered data bit and is not affected by the mask.

Top module: `eye_mask_classifier`

## Requirements
- R1: A timing point violates the mask only when its above-lower decision is 1 and its above-upper decision is 0. The combinations (0,0), (1,1) and (0,1) of (above-lower, above-upper) are not violations.
- R2: One clock after a cycle with `smp_valid`=1 in which no enabled point violates, `ind_up` is 1 for one cycle.
- R3: One clock after a valid cycle in which exactly one enabled point violates, `ind_down` is 1 for one cycle.
- R4: One clock after a valid cycle in which both points are enabled and both violate, `ind_bad` is 1 for one cycle.
- R5: Exactly one of `ind_up`, `ind_down` and `ind_bad` is 1 in the cycle after each valid cycle. All three are 0 in the cycle after a cycle with `smp_valid`=0.
- R6: `early_errs` increments by one in the cycle after a valid cycle with an enabled early violation. `late_errs` does the same for the late point. Each counter is independent of the other, and neither changes on cycles with `smp_valid`=0.
- R7: Each counter saturates at 65535 (16 bits) and holds there.
- R8: `cnt_clear`=1 sets both counters to 0 on the next edge and takes priority over an increment.
- R9: `mask_en[0]` enables the early check and `mask_en[1]` enables the late check. A disabled point counts as non-violating for grading and is never counted.
- R10: `data_out` takes `center_bit` on the edge after each valid cycle and holds it otherwise. It is unaffected by the mask or the thresholds.
- R11: While `rst_n`=0 (synchronous), the indicators, counters and `data_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Qualifies one bit period of samples |
| early_above_hi | input | 1 | Early level above upper threshold |
| early_above_lo | input | 1 | Early level above lower threshold |
| late_above_hi | input | 1 | Late level above upper threshold |
| late_above_lo | input | 1 | Late level above lower threshold |
| center_bit | input | 1 | Centre-of-eye data decision |
| mask_en | input | 2 | Bit 0 enables early check, bit 1 enables late check |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| ind_up | output | 1 | No-violation pulse |
| ind_down | output | 1 | Light-violation pulse |
| ind_bad | output | 1 | Severe-violation pulse |
| data_out | output | 1 | Recovered data bit |
| early_errs | output | 16 | Early violation count |
| late_errs | output | 16 | Late violation count |

## Verification
The assertions assume that the inputs are stable across each rising edge and that the comparator bits carry no unknowns. They also assume that the counters start from a reset before any increment is judged. The stimulus changes all inputs only on the falling edge. It draws the comparator pairs from all four combinations, including the physically impossible one, so that R1 sees every case. A long directed run of early violations drives the early counter into saturation while the late point stays clean.

// File: rtl/eye_mask_pkg.sv
// Package: shared types and sizes for the eye mask classifier.
// Assumes exactly two timing points (early = index 0, late = index 1).
package eye_mask_pkg;
    localparam int NUM_PTS = 2;
    localparam int PT_EARLY = 0;
    localparam int PT_LATE  = 1;

    typedef enum logic [1:0] {
        SEV_NONE   = 2'd0,
        SEV_LIGHT  = 2'd1,
        SEV_SEVERE = 2'd2
    } severity_e;
endpackage

// File: rtl/eye_point_check.sv
// Module: eye_point_check
// Decides whether one timing point lies inside the forbidden mask band.
// Assumes the comparator bits were latched upstream at the timing point.
// The inconsistent pair (above upper but not above lower) is not a violation.
module eye_point_check (
    input  logic above_hi,
    input  logic above_lo,
    input  logic enable,
    output logic violate
);
    // Purpose: level between thresholds on an enabled point.
    always_comb begin
        violate = enable & above_lo & ~above_hi;
    end
endmodule

// File: rtl/eye_err_counter.sv
// Module: eye_err_counter
// Saturating violation counter with a synchronous clear.
// Assumes inc is already qualified by the bit-period strobe.
module eye_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    // Purpose: clear first, otherwise count up until full scale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != FULL) begin
            count <= count + 1'b1;
        end
    end

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL && !clr) |=> count == FULL);
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == $past(count) + 1'b1));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/eye_grade.sv
// Module: eye_grade
// Grades a bit period by the number of violating points and registers the
// one-hot indicator pulses and the centre data bit.
// Assumes viol[] comes from eye_point_check with enables already applied.
module eye_grade
    import eye_mask_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic [NUM_PTS-1:0] viol,
    input  logic               center,
    output logic               up,
    output logic               down,
    output logic               bad,
    output logic               data
);
    severity_e sev;

    // Purpose: map the violation count to a severity level.
    always_comb begin
        case ($countones(viol))
            0:       sev = SEV_NONE;
            1:       sev = SEV_LIGHT;
            default: sev = SEV_SEVERE;
        endcase
    end

    // Purpose: emit a single pulse per valid bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up   <= 1'b0;
            down <= 1'b0;
            bad  <= 1'b0;
        end else begin
            up   <= valid && (sev == SEV_NONE);
            down <= valid && (sev == SEV_LIGHT);
            bad  <= valid && (sev == SEV_SEVERE);
        end
    end

    // Purpose: capture the recovered data bit on valid periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= 1'b0;
        end else if (valid) begin
            data <= center;
        end
    end

    p_one_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> $countones({up, down, bad}) == 1);
    p_no_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !(up || down || bad));
    p_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> data == $past(center));
    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(data));
endmodule

// File: rtl/eye_mask_classifier.sv
// Module: eye_mask_classifier (top)
// Checks the early and late samples against a rectangular mask, grades each
// bit period as UP / DOWN / BAD, and counts early and late violations apart.
// Assumes all inputs are synchronous to clk and held for one cycle per period.
module eye_mask_classifier
    import eye_mask_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             early_above_hi,
    input  logic             early_above_lo,
    input  logic             late_above_hi,
    input  logic             late_above_lo,
    input  logic             center_bit,
    input  logic [1:0]       mask_en,
    input  logic             cnt_clear,
    output logic             ind_up,
    output logic             ind_down,
    output logic             ind_bad,
    output logic             data_out,
    output logic [CNT_W-1:0] early_errs,
    output logic [CNT_W-1:0] late_errs
);
    logic [NUM_PTS-1:0] hi_bits;
    logic [NUM_PTS-1:0] lo_bits;
    logic [NUM_PTS-1:0] viol;
    logic [CNT_W-1:0]   counts [NUM_PTS];

    // Purpose: gather per-point comparator decisions into vectors.
    always_comb begin
        hi_bits[PT_EARLY] = early_above_hi;
        hi_bits[PT_LATE]  = late_above_hi;
        lo_bits[PT_EARLY] = early_above_lo;
        lo_bits[PT_LATE]  = late_above_lo;
    end

    for (genvar p = 0; p < NUM_PTS; p++) begin : g_pt
        eye_point_check u_chk (
            .above_hi (hi_bits[p]),
            .above_lo (lo_bits[p]),
            .enable   (mask_en[p]),
            .violate  (viol[p])
        );
        eye_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (smp_valid & viol[p]),
            .clr   (cnt_clear),
            .count (counts[p])
        );
    end

    eye_grade u_grade (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (smp_valid),
        .viol   (viol),
        .center (center_bit),
        .up     (ind_up),
        .down   (ind_down),
        .bad    (ind_bad),
        .data   (data_out)
    );

    // Purpose: expose the per-point counters on named ports.
    always_comb begin
        early_errs = counts[PT_EARLY];
        late_errs  = counts[PT_LATE];
    end

    p_severe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mask_en == 2'b11 && early_above_lo && !early_above_hi
         && late_above_lo && !late_above_hi) |=> ind_bad);
    p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !cnt_clear && !mask_en[0]) |=> $stable(early_errs));
    p_no_viol_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (early_above_hi || !early_above_lo)
         && (late_above_hi || !late_above_lo)) |=> ind_up);
    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (!ind_up && !ind_down && !ind_bad && !data_out
                    && early_errs == '0 && late_errs == '0));
endmodule

// File: tb/tb_eye_mask_classifier.sv
module tb_eye_mask_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC = 65535;

    logic clk = 1'b0;
    logic rst_n, smp_valid, e_hi, e_lo, l_hi, l_lo, center, cnt_clear;
    logic [1:0] mask_en;
    logic up, down, bad, data;
    logic [15:0] e_cnt, l_cnt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int x_up, x_down, x_bad, x_data, x_e, x_l;

    always #(CLK_PERIOD/2) clk = ~clk;

    eye_mask_classifier dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .early_above_hi(e_hi), .early_above_lo(e_lo),
        .late_above_hi(l_hi), .late_above_lo(l_lo),
        .center_bit(center), .mask_en(mask_en), .cnt_clear(cnt_clear),
        .ind_up(up), .ind_down(down), .ind_bad(bad), .data_out(data),
        .early_errs(e_cnt), .late_errs(l_cnt)
    );

    function automatic int viol_of(input logic hi, input logic lo, input logic en);
        return (en && lo && !hi) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " up"}, int'(up), x_up);
        chk({tag, " down"}, int'(down), x_down);
        chk({tag, " bad"}, int'(bad), x_bad);
        chk({tag, " data R10"}, int'(data), x_data);
        chk({tag, " early R6"}, int'(e_cnt), x_e);
        chk({tag, " late R6"}, int'(l_cnt), x_l);
    endtask

    // Drives one cycle (called just after a falling edge), updates the model, checks.
    task automatic step(input logic v, input logic eh, input logic el,
                        input logic lh, input logic ll, input logic c,
                        input logic [1:0] m, input logic clr, input string tag);
        int ve, vl, n;
        smp_valid = v; e_hi = eh; e_lo = el; l_hi = lh; l_lo = ll;
        center = c; mask_en = m; cnt_clear = clr;
        ve = viol_of(eh, el, m[0]);
        vl = viol_of(lh, ll, m[1]);
        n = ve + vl;
        @(posedge clk);
        x_up = (v && n == 0) ? 1 : 0;
        x_down = (v && n == 1) ? 1 : 0;
        x_bad = (v && n == 2) ? 1 : 0;
        if (v) x_data = int'(c);
        if (clr) begin
            x_e = 0; x_l = 0;
        end else if (v) begin
            if (ve == 1 && x_e < MAXC) x_e++;
            if (vl == 1 && x_l < MAXC) x_l++;
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; smp_valid = 0; e_hi = 0; e_lo = 0; l_hi = 0; l_lo = 0;
        center = 0; mask_en = 2'b11; cnt_clear = 0;
        x_up = 0; x_down = 0; x_bad = 0; x_data = 0; x_e = 0; x_l = 0;
        repeat (3) @(negedge clk);
        compare_all("R11 reset");
        rst_n = 1;

        // R1: every comparator pair at the early point, late clean
        step(1, 0, 0, 1, 1, 1, 2'b11, 0, "R1 below-both");
        step(1, 1, 1, 1, 1, 0, 2'b11, 0, "R1 above-both");
        step(1, 1, 0, 1, 1, 1, 2'b11, 0, "R1 inconsistent");
        step(1, 0, 1, 1, 1, 0, 2'b11, 0, "R1 R3 in-band early");
        // R2/R3/R4/R5
        step(1, 1, 1, 0, 0, 1, 2'b11, 0, "R2 clean");
        step(1, 1, 1, 0, 1, 0, 2'b11, 0, "R3 late only");
        step(1, 0, 1, 0, 1, 1, 2'b11, 0, "R4 both");
        step(0, 0, 1, 0, 1, 0, 2'b11, 0, "R5 idle");
        // R9 masks
        step(1, 0, 1, 0, 1, 1, 2'b10, 0, "R9 early masked");
        step(1, 0, 1, 0, 1, 0, 2'b01, 0, "R9 late masked");
        step(1, 0, 1, 0, 1, 1, 2'b00, 0, "R9 both masked");
        // R8 clear beats increment
        step(1, 0, 1, 0, 1, 0, 2'b11, 1, "R8 clear");
        step(0, 0, 1, 0, 1, 1, 2'b11, 0, "R10 hold");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [9:0] r;
            r = 10'($urandom);
            step(r[0] | r[1], r[2], r[3], r[4], r[5], r[6], r[8:7],
                 ($urandom % 97) == 0, "rand R2 R3 R4 R6");
        end

        // R7 saturation of early counter, late stays clean
        step(0, 0, 0, 0, 0, 0, 2'b11, 1, "R8 pre-sat clear");
        for (int i = 0; i < MAXC + 4; i++) begin
            step(1, 0, 1, 1, 1, 1'(i), 2'b11, 0, "R7 saturate");
        end
        chk("R7 final early", int'(e_cnt), MAXC);
        chk("R7 late untouched", int'(l_cnt), 0);
        step(1, 0, 1, 0, 1, 0, 2'b11, 1, "R8 clear from full");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule